// File: doc/BRIEF.md
# Automatic Data-Rate Standard Hunter

This block picks which of four serial data-rate standards an external clock-recovery receiver should try to lock to. It keeps a small select counter and presents it on a two-bit output. A slow, free-running tick steps the counter through the candidate standards one after another. The search stops as soon as the framer starts reporting timing references. As long as references keep arriving between ticks, the current standard is kept. When they stop, the search starts again from the current standard.

The framer reports each detected timing reference by toggling a level signal. The direction of the toggle carries no meaning; only the fact that it changed matters. That signal may come from another clock domain. It is re-timed through a flop chain, and both of its edges are treated as one reference event. An enable input switches automatic selection on or off. While it is off, the selection is frozen.

Top module: `std_hunter`

## Requirements
- R1: Synchronous active-high reset sets `std_sel_o` to 0 and leaves the hunter disarmed, so the first tick after reset does not advance the selection.
- R2: `std_sel_o` changes only on a clock edge where `tick_i` (a one-cycle pulse) is high; without a tick it holds its value.
- R3: With `auto_en_i` high, a tick advances `std_sel_o` by exactly one if the hunter was armed by the previous tick and no reference event occurred since then. Every tick arms the hunter for the next interval.
- R4: Advancing from 3 wraps `std_sel_o` to 0, and hunting continues from there.
- R5: A reference event between two ticks cancels the advance at the second tick. While events keep arriving in every interval, the selection holds.
- R6: A rising or a falling transition of `ref_toggle_i` is each one reference event. After a change of `ref_toggle_i`, the event takes effect on any tick sampled three or more clock edges later.
- R7: A reference event that is consumed on the same edge as a tick cancels that tick's advance. That tick still arms the hunter, so the next event-free interval advances.
- R8: With `auto_en_i` low, ticks are ignored and `std_sel_o` is frozen. After `auto_en_i` returns high, the first tick only arms the hunter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hunter clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_en_i | input | 1 | Enables automatic standard selection |
| tick_i | input | 1 | One-cycle pulse from the slow oscillator |
| ref_toggle_i | input | 1 | Framer reference indicator, toggles once per timing reference |
| std_sel_o | output | 2 | Selected standard index, 0 to 3 |

## Verification
A tick changes `std_sel_o` on the edge that samples it. The bench therefore raises the tick at one falling clock edge and compares the output at the next falling edge. A reference toggle needs three edges before the hunter sees it. For that reason, ordinary reference cases wait four clock cycles before the next tick. The coincidence case of R7 instead places the tick exactly two falling edges after the toggle, which is the edge where the event is consumed. Each expected value is queued by the driver once its edge has passed, and the monitor compares it at that moment.

// File: rtl/hunter_pkg.sv
package hunter_pkg;

    localparam int SEL_W_DEF  = 2;
    localparam int STAGES_DEF = 2;

    // Per-cycle control inputs seen by the arming logic
    typedef struct packed {
        logic en;
        logic tick;
        logic hit;
    } hunt_ev_t;

    function automatic hunt_ev_t make_ev(input logic en, input logic tick, input logic hit);
        hunt_ev_t e;
        e.en   = en;
        e.tick = tick;
        e.hit  = hit;
        return e;
    endfunction

    // Next armed state: disabled clears, tick arms, lone event disarms
    function automatic logic next_armed(input hunt_ev_t e, input logic armed);
        if (!e.en)
            return 1'b0;
        else if (e.tick)
            return 1'b1;
        else if (e.hit)
            return 1'b0;
        return armed;
    endfunction

endpackage

// File: rtl/hunter_sync.sv
module hunter_sync #(
    parameter int STAGES = hunter_pkg::STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic hit_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], async_i};
    end

    // Either direction of a settled transition is one event
    assign hit_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/hunter_arm.sv
module hunter_arm
    import hunter_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hunt_ev_t ev_i,
    output logic     adv_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else
            armed <= next_armed(ev_i, armed);
    end

    assign adv_o = ev_i.en & ev_i.tick & armed & ~ev_i.hit;
endmodule

// File: rtl/hunter_count.sv
module hunter_count #(
    parameter int SEL_W = hunter_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [SEL_W-1:0] sel_o
);
    always_ff @(posedge clk) begin
        if (rst)
            sel_o <= '0;
        else if (adv_i)
            sel_o <= sel_o + 1'b1;   // natural wrap at the top
    end
endmodule

// File: rtl/std_hunter.sv
module std_hunter
    import hunter_pkg::*;
#(
    parameter int SEL_W  = SEL_W_DEF,
    parameter int STAGES = STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en_i,
    input  logic             tick_i,
    input  logic             ref_toggle_i,
    output logic [SEL_W-1:0] std_sel_o
);
    logic     ref_hit;
    logic     advance;
    hunt_ev_t ev;

    hunter_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(ref_toggle_i),
        .hit_o  (ref_hit)
    );

    assign ev = make_ev(auto_en_i, tick_i, ref_hit);

    hunter_arm u_arm (
        .clk  (clk),
        .rst  (rst),
        .ev_i (ev),
        .adv_o(advance)
    );

    hunter_count #(.SEL_W(SEL_W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .adv_i(advance),
        .sel_o(std_sel_o)
    );
endmodule

// File: rtl/hunter_chk.sv
module hunter_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             auto_en_i,
    input logic             tick_i,
    input logic             hit_i,
    input logic [SEL_W-1:0] std_sel_o
);
    // R1: reset forces selection 0
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> std_sel_o == '0);

    // R2: no tick, no change
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick_i)) |-> $stable(std_sel_o));

    // R3 and R4: every change is a single modular step
    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(std_sel_o)) |->
            std_sel_o == SEL_W'($past(std_sel_o) + 1'b1));

    // R5: a consumed reference event blocks the advance
    assert_event_holds_R5: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> $stable(std_sel_o));

    // R8: disabled means frozen
    assert_frozen_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(auto_en_i)) |-> $stable(std_sel_o));
endmodule

bind std_hunter hunter_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .auto_en_i(auto_en_i),
    .tick_i   (tick_i),
    .hit_i    (ref_hit),
    .std_sel_o(std_sel_o)
);

// File: tb/std_hunter_tb.sv
module std_hunter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_en_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       ref_toggle_i = 1'b0;
    logic [1:0] std_sel_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  ev_check;

    always #10 clk = ~clk;   // 50 MHz

    std_hunter u_dut (
        .clk         (clk),
        .rst         (rst),
        .auto_en_i   (auto_en_i),
        .tick_i      (tick_i),
        .ref_toggle_i(ref_toggle_i),
        .std_sel_o   (std_sel_o)
    );

    // Monitor: pops one expectation per trigger and compares
    always begin
        @(ev_check);
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (std_sel_o !== it.exp) begin
                n_errors++;
                $display("FAIL %s: std_sel_o actual=%0d expected=%0d", it.tag, std_sel_o, it.exp);
            end
        end
    end

    task automatic expect_now(input logic [1:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        ->ev_check;
        #1;
    endtask

    // Tick for one cycle; the result is due on the edge that samples it
    task automatic tick_expect(input logic [1:0] exp, input string tag);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        expect_now(exp, tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic ref_event();
        @(negedge clk) ref_toggle_i = ~ref_toggle_i;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now(2'd0, "R1 reset value");
        tick_expect(2'd0, "R1 first tick only arms");
        tick_expect(2'd1, "R3 advance 0->1");
        tick_expect(2'd2, "R3 advance 1->2");
        tick_expect(2'd3, "R3 advance 2->3");
        tick_expect(2'd0, "R4 wrap 3->0");
        tick_expect(2'd1, "R4 hunting continues");
        repeat (5) @(negedge clk);
        expect_now(2'd1, "R2 hold without tick");
        ref_event();                       // rising toggle
        tick_expect(2'd1, "R5 event cancels advance");
        ref_event();                       // falling toggle
        tick_expect(2'd1, "R6 falling toggle is an event");
        tick_expect(2'd2, "R5 resumes after events stop");
        // R7: tick sampled on the edge where the event is consumed
        @(negedge clk) ref_toggle_i = ~ref_toggle_i;
        @(negedge clk);
        tick_expect(2'd2, "R7 coincident event blocks");
        tick_expect(2'd3, "R7 coincident tick still arms");
        @(negedge clk) auto_en_i = 1'b0;
        tick_expect(2'd3, "R8 disabled tick ignored");
        tick_expect(2'd3, "R8 disabled stays frozen");
        @(negedge clk) auto_en_i = 1'b1;
        tick_expect(2'd3, "R8 first tick after enable arms");
        tick_expect(2'd0, "R8 then advances with wrap");
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        expect_now(2'd0, "R1 reset from nonzero");
        tick_expect(2'd0, "R1 disarmed after reset");
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        #2;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule